// File: doc/BRIEF.md
# Memory Module Presence-Data Stream Checker

This block watches the first 64 bytes of a memory module's serial presence data as they come back from a sequential EEPROM read. Each byte arrives with a valid strobe and its byte index. While the stream passes, the block keeps a modulo-256 running sum of bytes 0 to 62. When byte 63 arrives, it compares that byte against the sum. Along the way it captures and decodes the fields that a memory controller's start-up logic needs: whether the module holds SDRAM, the highest CAS latency the devices support, and the minimum clock period at the highest, second and third CAS latencies. All three periods are given as integers in tenths of a nanosecond.

The results are valid when a one-cycle done pulse appears. They then stay unchanged until the next start. A start pulse clears the accumulator and every output and prepares the block for a fresh stream. The block also flags bytes whose index breaks the strict 0, 1, 2, ... order, either by skipping an index or by repeating one. These flagged bytes are still summed and decoded.

Top module: `spd_stream_checker`

## Requirements
- R1: When byte 63 is accepted, `csum_ok_o` becomes 1 if that byte equals the low 8 bits of the sum of every byte accepted before it in the stream, and 0 otherwise.
- R2: `sdram_o` is 1 when the byte at index 2 equals 0x04. Any other value, including 0x02 (EDO), gives 0.
- R3: `cas_max_o` equals k+1, where k is the highest set bit among bits 6..0 of the byte at index 18. Bit 7 of that byte has no effect.
- R4: When bits 6..0 of byte 18 are all zero, `cas_max_o` is 0 and `cas_none_o` is 1. Otherwise `cas_none_o` is 0.
- R5: `tck_top_o` equals (bits 7:4 of byte 9) × 10 + (bits 3:0 of byte 9).
- R6: `tck_second_o` decodes byte 23 like R5, except that a whole-nanosecond nibble of 1, 2 or 3 stands for 16, 17 or 18 ns.
- R7: `tck_third_o` equals (bits 7:2 of byte 25) × 10 + r, where r is 0, 3, 5 or 8 for bits 1:0 equal to 0, 1, 2 or 3. A zero byte therefore yields 0.
- R8: `done_o` goes high for exactly one cycle, on the clock edge after the edge that samples byte 63.
- R9: `seq_err_o` is set when an accepted byte's index differs from the expected one. The expected index is 0 for the first byte and the previous accepted index + 1 after that. The flag stays set until start.
- R10: A start pulse clears the sum, every output and the sequence state, starting on the next edge. A byte presented in the same cycle as start is dropped.
- R11: After done, valid bytes are ignored until the next start. The outputs hold and no further done pulse appears.
- R12: After reset all outputs are 0, and the block accepts a stream starting at index 0 without needing a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear and re-arm for a new stream |
| in_valid | input | 1 | Byte strobe |
| in_idx | input | 6 | Byte index within the stream |
| in_data | input | 8 | Byte value |
| done_o | output | 1 | One-cycle pulse when the results are complete |
| csum_ok_o | output | 1 | Stored checksum matches the running sum |
| sdram_o | output | 1 | Module memory type is SDRAM |
| cas_max_o | output | 3 | Highest supported CAS latency, 0 if none |
| cas_none_o | output | 1 | Latency mask is empty |
| tck_top_o | output | 10 | Cycle time at the highest latency, in 0.1 ns |
| tck_second_o | output | 10 | Cycle time at the second latency, in 0.1 ns |
| tck_third_o | output | 10 | Cycle time at the third latency, in 0.1 ns |
| seq_err_o | output | 1 | Byte order violation seen since start |

## Verification
A corrupted running sum shows only at the done pulse, as a wrong `csum_ok_o` one cycle after byte 63. The scoreboard therefore compares every field on each done and varies the stored checksum so that the result is both 0 and 1. A wrong idle or expected-index state shows sooner: it appears as an extra or missing done pulse, or as a `seq_err_o` that is set or cleared in the cycle after the offending byte. The bench looks for these through repeated indices, restarts in mid-stream and bytes sent after done. Decoder faults show directly on the captured fields, one edge after the byte concerned.

// File: rtl/spd_chk_pkg.sv
package spd_chk_pkg;
   // fixed-point layouts used by the cycle-time bytes
   typedef enum logic [1:0] {
      TFMT_TENTH      = 2'd0,
      TFMT_TENTH_ROLL = 2'd1,
      TFMT_QUARTER    = 2'd2
   } tfmt_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/spd_time_dec.sv
module spd_time_dec
   import spd_chk_pkg::*;
#(
   parameter tfmt_e FMT   = TFMT_TENTH,
   parameter int    OUT_W = 10
) (
   input  logic [BYTE_W-1:0] code,
   output logic [OUT_W-1:0]  tenths
);
   if (OUT_W < 10) begin : g_bad_width
      $error("spd_time_dec: OUT_W must hold 638");
   end

   if (FMT == TFMT_QUARTER) begin : g_quarter
      logic [3:0] frac;
      always_comb begin
         case (code[1:0])
            2'd0:    frac = 4'd0;
            2'd1:    frac = 4'd3;
            2'd2:    frac = 4'd5;
            default: frac = 4'd8;
         endcase
         tenths = OUT_W'(code[7:2]) * OUT_W'(10) + OUT_W'(frac);
      end
   end else begin : g_nibble
      logic [4:0] whole;
      always_comb begin
         whole = 5'(code[7:4]);
         if (FMT == TFMT_TENTH_ROLL && code[7:4] != 4'd0 && code[7:4] < 4'd4)
            whole = 5'(code[7:4]) + 5'd15;
         tenths = OUT_W'(whole) * OUT_W'(10) + OUT_W'(code[3:0]);
      end
   end
endmodule

// File: rtl/spd_cas_pick.sv
module spd_cas_pick #(
   parameter  int MASK_W = 7,
   localparam int LVL_W  = $clog2(MASK_W + 1)
) (
   input  logic [MASK_W-1:0] mask,
   output logic [LVL_W-1:0]  lvl,
   output logic              none
);
   if (MASK_W < 1) begin : g_bad_mask
      $error("spd_cas_pick: MASK_W must be at least 1");
   end

   always_comb begin
      lvl = '0;
      for (int k = 0; k < MASK_W; k++) begin
         if (mask[k]) lvl = LVL_W'(k + 1);
      end
      none = (mask == '0);
   end
endmodule

// File: rtl/spd_sum_acc.sv
module spd_sum_acc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         add_en,
   input  logic [W-1:0] add_val,
   output logic [W-1:0] sum
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum <= '0;
      else if (clr)    sum <= '0;
      else if (add_en) sum <= sum + add_val;
   end

   // R10
   sum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sum == '0));

   // R1
   sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !add_en) |=> $stable(sum));
endmodule

// File: rtl/spd_stream_checker.sv
module spd_stream_checker
   import spd_chk_pkg::*;
#(
   parameter  int IDX_W     = 6,
   parameter  int TIME_W    = 10,
   parameter  int LAST_IDX  = 63,
   parameter  int TYPE_IDX  = 2,
   parameter  int CAS_IDX   = 18,
   parameter  int CAS_BITS  = 7,
   parameter  int T1_IDX    = 9,
   parameter  int T2_IDX    = 23,
   parameter  int T3_IDX    = 25,
   localparam int CAS_LW    = $clog2(CAS_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic [BYTE_W-1:0] in_data,
   output logic              done_o,
   output logic              csum_ok_o,
   output logic              sdram_o,
   output logic [CAS_LW-1:0] cas_max_o,
   output logic              cas_none_o,
   output logic [TIME_W-1:0] tck_top_o,
   output logic [TIME_W-1:0] tck_second_o,
   output logic [TIME_W-1:0] tck_third_o,
   output logic              seq_err_o
);
   localparam logic [IDX_W-1:0]  LAST_I   = IDX_W'(LAST_IDX);
   localparam logic [BYTE_W-1:0] SDRAM_ID = 8'h04;

   if (LAST_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("spd_stream_checker: LAST_IDX does not fit IDX_W");
   end
   if (CAS_BITS > BYTE_W) begin : g_bad_cas
      $error("spd_stream_checker: CAS_BITS wider than a byte");
   end

   logic              idle;
   logic [IDX_W-1:0]  exp_idx;
   logic [BYTE_W-1:0] sum;
   logic              accept;
   logic              is_last;
   logic [CAS_LW-1:0] cas_lvl;
   logic              cas_empty;
   logic [TIME_W-1:0] t1_dec, t2_dec, t3_dec;

   assign accept  = in_valid && !idle && !start;
   assign is_last = (in_idx == LAST_I);

   spd_sum_acc #(.W(BYTE_W)) u_sum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .add_en  (accept && !is_last),
      .add_val (in_data),
      .sum     (sum)
   );

   spd_cas_pick #(.MASK_W(CAS_BITS)) u_cas (
      .mask (in_data[CAS_BITS-1:0]),
      .lvl  (cas_lvl),
      .none (cas_empty)
   );

   spd_time_dec #(.FMT(TFMT_TENTH), .OUT_W(TIME_W)) u_t1 (
      .code (in_data), .tenths (t1_dec));
   spd_time_dec #(.FMT(TFMT_TENTH_ROLL), .OUT_W(TIME_W)) u_t2 (
      .code (in_data), .tenths (t2_dec));
   spd_time_dec #(.FMT(TFMT_QUARTER), .OUT_W(TIME_W)) u_t3 (
      .code (in_data), .tenths (t3_dec));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle         <= 1'b0;
         exp_idx      <= '0;
         done_o       <= 1'b0;
         csum_ok_o    <= 1'b0;
         sdram_o      <= 1'b0;
         cas_max_o    <= '0;
         cas_none_o   <= 1'b0;
         tck_top_o    <= '0;
         tck_second_o <= '0;
         tck_third_o  <= '0;
         seq_err_o    <= 1'b0;
      end else if (start) begin
         idle         <= 1'b0;
         exp_idx      <= '0;
         done_o       <= 1'b0;
         csum_ok_o    <= 1'b0;
         sdram_o      <= 1'b0;
         cas_max_o    <= '0;
         cas_none_o   <= 1'b0;
         tck_top_o    <= '0;
         tck_second_o <= '0;
         tck_third_o  <= '0;
         seq_err_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (accept) begin
            exp_idx <= in_idx + 1'b1;
            if (in_idx != exp_idx) seq_err_o <= 1'b1;
            if (is_last) begin
               done_o    <= 1'b1;
               idle      <= 1'b1;
               csum_ok_o <= (sum == in_data);
            end
            if (in_idx == IDX_W'(TYPE_IDX)) sdram_o <= (in_data == SDRAM_ID);
            if (in_idx == IDX_W'(CAS_IDX)) begin
               cas_max_o  <= cas_lvl;
               cas_none_o <= cas_empty;
            end
            if (in_idx == IDX_W'(T1_IDX)) tck_top_o    <= t1_dec;
            if (in_idx == IDX_W'(T2_IDX)) tck_second_o <= t2_dec;
            if (in_idx == IDX_W'(T3_IDX)) tck_third_o  <= t3_dec;
         end
      end
   end

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4
   cas_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cas_none_o |-> (cas_max_o == '0));

   // R9
   seq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_err_o && !start) |=> seq_err_o);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !start) |=> (!done_o && $stable(csum_ok_o) && $stable(tck_top_o)
                            && $stable(tck_second_o) && $stable(tck_third_o)
                            && $stable(cas_max_o) && $stable(sdram_o)));

   // R7
   quarter_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tck_third_o % TIME_W'(10)) inside {TIME_W'(0), TIME_W'(3), TIME_W'(5), TIME_W'(8)}));

   // R10
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done_o && !seq_err_o && !csum_ok_o && cas_max_o == '0
                 && tck_top_o == '0 && tck_third_o == '0));
endmodule

// File: tb/tb_spd_stream_checker.sv
module tb_spd_stream_checker;
   typedef struct packed {
      logic       ok;
      logic       sd;
      logic [2:0] cas;
      logic       none;
      logic [9:0] t1;
      logic [9:0] t2;
      logic [9:0] t3;
      logic       seq;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       in_valid = 1'b0;
   logic [5:0] in_idx = '0;
   logic [7:0] in_data = '0;
   logic       done_o, csum_ok_o, sdram_o, cas_none_o, seq_err_o;
   logic [2:0] cas_max_o;
   logic [9:0] tck_top_o, tck_second_o, tck_third_o;

   int n_checks = 0;
   int n_errors = 0;
   int n_pushed = 0;
   int n_popped = 0;
   bit finished = 0;

   exp_t       sb_q[$];
   exp_t       last_exp;
   logic [7:0] img [0:63];

   // reference state
   logic [7:0] m_sum;
   logic [5:0] m_exp;
   bit         m_idle;
   exp_t       m_cur;

   always #5 clk = ~clk;

   spd_stream_checker dut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_idx(in_idx), .in_data(in_data), .done_o(done_o),
      .csum_ok_o(csum_ok_o), .sdram_o(sdram_o), .cas_max_o(cas_max_o),
      .cas_none_o(cas_none_o), .tck_top_o(tck_top_o),
      .tck_second_o(tck_second_o), .tck_third_o(tck_third_o),
      .seq_err_o(seq_err_o));

   task automatic check(input bit good, input string tag, input int act, input int exp);
      n_checks++;
      if (!good) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [9:0] ref_nib(input logic [7:0] b, input bit roll);
      int w = int'(b[7:4]);
      if (roll && w >= 1 && w <= 3) w = w + 15;
      return 10'(w * 10 + int'(b[3:0]));
   endfunction

   function automatic logic [9:0] ref_qtr(input logic [7:0] b);
      int r;
      r = (b[1:0] == 2'd0) ? 0 : (b[1:0] == 2'd1) ? 3 : (b[1:0] == 2'd2) ? 5 : 8;
      return 10'(int'(b[7:2]) * 10 + r);
   endfunction

   task automatic model_clear();
      m_sum = '0; m_exp = '0; m_idle = 0; m_cur = '0;
   endtask

   task automatic send_byte(input logic [5:0] idx, input logic [7:0] d);
      @(negedge clk);
      in_valid = 1'b1; in_idx = idx; in_data = d;
      if (!m_idle) begin
         if (idx != m_exp) m_cur.seq = 1'b1;
         m_exp = idx + 6'd1;
         if (idx == 6'd2) m_cur.sd = (d == 8'h04);
         if (idx == 6'd18) begin
            m_cur.cas = 3'd0;
            for (int k = 6; k >= 0; k--) begin
               if (d[k] && m_cur.cas == 3'd0) m_cur.cas = 3'(k + 1);
            end
            m_cur.none = (d[6:0] == 7'd0);
         end
         if (idx == 6'd9)  m_cur.t1 = ref_nib(d, 1'b0);
         if (idx == 6'd23) m_cur.t2 = ref_nib(d, 1'b1);
         if (idx == 6'd25) m_cur.t3 = ref_qtr(d);
         if (idx == 6'd63) begin
            m_cur.ok = (m_sum == d);
            sb_q.push_back(m_cur);
            n_pushed++;
            last_exp = m_cur;
            m_idle = 1;
         end else begin
            m_sum = m_sum + d;
         end
      end
   endtask

   task automatic release_bus();
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      model_clear();
   endtask

   task automatic build(input logic [7:0] typ, input logic [7:0] cas, input logic [7:0] b9,
                        input logic [7:0] b23, input logic [7:0] b25, input bit bad_sum);
      logic [7:0] s = '0;
      for (int i = 0; i < 63; i++) img[i] = 8'(i * 7 + 3);
      img[2] = typ; img[18] = cas; img[9] = b9; img[23] = b23; img[25] = b25;
      for (int i = 0; i < 63; i++) s = s + img[i];
      img[63] = bad_sum ? s + 8'd1 : s;
   endtask

   task automatic send_image();
      for (int i = 0; i < 64; i++) send_byte(6'(i), img[i]);
      release_bus();
   endtask

   task automatic check_zero(input string tag);
      check(done_o == 0 && csum_ok_o == 0 && sdram_o == 0 && cas_max_o == 0
            && cas_none_o == 0 && tck_top_o == 0 && tck_second_o == 0
            && tck_third_o == 0 && seq_err_o == 0, tag,
            int'(tck_top_o) + int'(cas_max_o) + int'(seq_err_o), 0);
   endtask

   // monitor: pops and compares on every done pulse
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (done_o) begin
            if (sb_q.size() == 0) begin
               check(0, "R11 unexpected done", 1, 0);
            end else begin
               e = sb_q.pop_front();
               n_popped++;
               check(csum_ok_o == e.ok, "R1 csum_ok", csum_ok_o, e.ok);
               check(sdram_o == e.sd, "R2 sdram", sdram_o, e.sd);
               check(cas_max_o == e.cas, "R3 cas_max", cas_max_o, e.cas);
               check(cas_none_o == e.none, "R4 cas_none", cas_none_o, e.none);
               check(tck_top_o == e.t1, "R5 tck_top", tck_top_o, e.t1);
               check(tck_second_o == e.t2, "R6 tck_second", tck_second_o, e.t2);
               check(tck_third_o == e.t3, "R7 tck_third", tck_third_o, e.t3);
               check(seq_err_o == e.seq, "R9 seq_err", seq_err_o, e.seq);
            end
            @(negedge clk);
            // R8: single-cycle pulse
            check(done_o == 0, "R8 done width", done_o, 0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         check(0, "watchdog", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      // R12 reset state
      check_zero("R12 reset outputs");
      rst_n = 1'b1;
      @(negedge clk);
      check_zero("R12 after reset release");

      // typical SDRAM image, no start needed after reset (R12)
      build(8'h04, 8'h06, 8'h75, 8'hA0, 8'h3E, 0);
      send_image();
      check(int'(tck_top_o) == 75, "R5 literal 0x75", tck_top_o, 75);

      // R11: bytes after done are ignored
      build(8'h02, 8'h00, 8'h11, 8'h15, 8'h00, 1);
      send_image();
      check(tck_top_o == last_exp.t1 && tck_second_o == last_exp.t2,
            "R11 outputs held", tck_top_o, last_exp.t1);
      check(sdram_o == last_exp.sd, "R11 sdram held", sdram_o, last_exp.sd);

      // EDO, empty latency mask, rolled-up nibble, bad checksum
      pulse_start();
      check_zero("R10 start clears");
      build(8'h02, 8'h00, 8'h00, 8'h15, 8'h00, 1);
      send_image();
      check(int'(tck_second_o) == 165, "R6 rollup 0x15", tck_second_o, 165);

      // full mask, maximal nibbles
      pulse_start();
      build(8'h04, 8'hFF, 8'hF9, 8'h35, 8'h07, 0);
      send_image();
      check(int'(tck_third_o) == 18, "R7 quarter code 3", tck_third_o, 18);

      // bit 7 only extra, non-SDRAM code, plain nibble above rollup
      pulse_start();
      build(8'h07, 8'h81, 8'h48, 8'h45, 8'h05, 0);
      send_image();
      check(int'(cas_max_o) == 1, "R3 bit7 ignored", cas_max_o, 1);

      // R9: repeated index
      pulse_start();
      build(8'h04, 8'h0C, 8'h60, 8'h2F, 8'h29, 0);
      for (int i = 0; i < 64; i++) begin
         send_byte(6'(i), img[i]);
         if (i == 5) send_byte(6'd5, img[5]);
      end
      release_bus();

      // R10: restart mid-stream, then a clean stream; byte with start dropped
      pulse_start();
      build(8'h04, 8'h04, 8'h99, 8'h16, 8'hFC, 0);
      for (int i = 0; i < 20; i++) send_byte(6'(i), img[i]);
      @(negedge clk);
      start = 1'b1; in_valid = 1'b1; in_idx = 6'd20; in_data = 8'hAA;
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0;
      model_clear();
      check_zero("R10 mid-stream clear");
      build(8'h04, 8'h20, 8'h50, 8'h75, 8'h1D, 0);
      send_image();
      check(seq_err_o == 0, "R10 clean after restart", seq_err_o, 0);

      repeat (4) @(negedge clk);
      check(n_popped == n_pushed && sb_q.size() == 0, "R8 done count",
            n_popped, n_pushed);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule